// File: doc/BRIEF.md
# Sixteen-Round Table-Driven Feistel Block Cipher Core

This core encrypts or decrypts a single 64-bit block with a 16-round Feistel network. It does not derive its keys itself. Before use, software or another block loads four substitution tables and an 18-word subkey file through a word-write port. Each substitution table holds 256 words of 32 bits. Each round looks up one byte of the current left half in each of the four tables and mixes the four results with an add, xor, add chain. Decryption uses the same datapath and walks the subkey file in reverse.

A one-cycle `start` pulse captures `in_block` and the direction bit `decrypt`, and the core then becomes busy. The result appears on `out_block` together with a one-cycle `done` pulse, a fixed 33 cycles after the start was accepted. There is no back-pressure on either side. A start while busy is dropped, and the result is simply held on `out_block` until the next operation completes, so a consumer that misses `done` can still read the block later. The tables live in synchronous RAM with a registered read, so each round takes one cycle to look up and one cycle to mix.

Top module: `sfc_core`

## Requirements
- R1: `in_block[63:32]` is the left half and `in_block[31:0]` the right half, so the first big-endian word on the wire is the left half. `out_block` uses the same convention.
- R2: The round function splits a 32-bit word into bytes a=[31:24], b=[23:16], c=[15:8], d=[7:0]. It returns ((T0[a] + T1[b]) xor T2[c]) + T3[d], with both additions taken modulo 2^32.
- R3: Encryption (`decrypt`=0) runs 16 rounds for k = 0..15. Each round does L ^= K[k], then R ^= F(L), then swaps the halves. Afterwards `out_block` = {R ^ K[17], L ^ K[16]}, where L and R are the halves held after the last swap.
- R4: Decryption (`decrypt`=1) uses keys K[17] down to K[2] for the rounds and K[0] (upper half) and K[1] (lower half) for the final step. Decrypting an encrypted block returns the original.
- R5: A write with `tbl_we`=1 stores `tbl_data` as follows. `tbl_sel` 0 to 3 writes entry `tbl_idx` of table T0 to T3. `tbl_sel`=4 writes key K[`tbl_idx`] for an index from 0 to 17. Any other select value, or a key index of 18 or more, changes nothing.
- R6: `done` goes high for exactly one cycle, 33 clock edges after the edge that accepted `start`.
- R7: `busy` is high from the accepting edge until `done` rises. A `start` while busy is ignored and does not change the block or the direction being processed.
- R8: `out_block` changes only at the edge that raises `done`, and it holds its value through later idle cycles.
- R9: Table and key writes while `busy` is high are ignored.
- R10: Reset returns the controller to idle (`busy`=0, `done`=0), even in the middle of an operation. Tables and keys keep their contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| tbl_we | input | 1 | Table/key write strobe |
| tbl_sel | input | 3 | 0 to 3 selects a substitution table, 4 selects the key file |
| tbl_idx | input | 8 | Entry index |
| tbl_data | input | 32 | Write data |
| start | input | 1 | Begin an operation (taken only when idle) |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_block | input | 64 | Input block {L, R} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_block | output | 64 | Result block, held until the next completion |

## Verification
The bench uses the default configuration: 16 rounds, 256-entry tables and 18 keys, which is the only size the cipher defines. At this size every table entry and every key can be written and mirrored in the bench's arithmetic reference. Each result is compared word for word against a bench-computed value for many pseudo-random blocks in both directions, and each ciphertext is also decrypted and checked against its original block. Timing corners are reached directly on this configuration: the exact 33-cycle latency, a start and key writes injected while busy, and a reset in the middle of a block.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int N_TABLE = WORD_W / BYTE_W;
  localparam int SEL_W   = 3;
  localparam logic [SEL_W-1:0] SEL_KEYS = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_MIX   = 2'd2,
    ST_FINAL = 2'd3
  } sfc_state_e;
endpackage

// File: rtl/sfc_sbox_ram.sv
module sfc_sbox_ram #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Contents are deliberately not reset.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfc_subkey_file.sv
module sfc_subkey_file #(
  parameter int N  = 18,
  parameter int W  = 32,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ridx_a,
  output logic [W-1:0]         rdata_a,
  input  logic [$clog2(N)-1:0] ridx_b,
  output logic [W-1:0]         rdata_b
);
  localparam int KW = $clog2(N);

  logic [W-1:0] keys [N];
  logic         in_range;

  assign in_range = (widx < IW'(N));

  always_ff @(posedge clk) begin
    if (we && in_range) keys[widx[KW-1:0]] <= wdata;
  end

  assign rdata_a = (ridx_a < KW'(N)) ? keys[ridx_a] : '0;
  assign rdata_b = (ridx_b < KW'(N)) ? keys[ridx_b] : '0;
endmodule

// File: rtl/sfc_round_fn.sv
module sfc_round_fn #(
  parameter int W = 32
) (
  input  logic [W-1:0] q0,
  input  logic [W-1:0] q1,
  input  logic [W-1:0] q2,
  input  logic [W-1:0] q3,
  output logic [W-1:0] f
);
  logic [W-1:0] sum01;
  logic [W-1:0] mixed;

  always_comb begin
    sum01 = q0 + q1;
    mixed = sum01 ^ q2;
    f     = mixed + q3;
  end
endmodule

// File: rtl/sfc_core.sv
module sfc_core
  import sfc_pkg::*;
#(
  parameter int NUM_ROUNDS = 16,
  parameter int IDX_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_we,
  input  logic [SEL_W-1:0]    tbl_sel,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [WORD_W-1:0]   tbl_data,
  input  logic                start,
  input  logic                decrypt,
  input  logic [2*WORD_W-1:0] in_block,
  output logic                busy,
  output logic                done,
  output logic [2*WORD_W-1:0] out_block
);
  localparam int NUM_KEYS = NUM_ROUNDS + 2;
  localparam int KEY_W    = $clog2(NUM_KEYS);
  localparam int RND_W    = $clog2(NUM_ROUNDS);
  localparam int LATENCY  = 2 * NUM_ROUNDS + 1;
  localparam int LAT_W    = $clog2(LATENCY + 2);

  sfc_state_e        state_q;
  logic [RND_W-1:0]  round_q;
  logic              mode_q;
  logic [WORD_W-1:0] l_q, r_q;
  logic [WORD_W-1:0] key_a, key_b, mix_in, f_val;
  logic [KEY_W-1:0]  idx_a, idx_b;
  logic [WORD_W-1:0] tq [N_TABLE];
  logic              accept, wr_open;

  assign busy    = (state_q != ST_IDLE);
  assign accept  = start && !busy;
  assign wr_open = tbl_we && !busy;

  // Key index selection: round key, or the final whitening pair.
  always_comb begin
    if (state_q == ST_FINAL) begin
      idx_a = mode_q ? KEY_W'(0) : KEY_W'(NUM_KEYS - 1);
      idx_b = mode_q ? KEY_W'(1) : KEY_W'(NUM_KEYS - 2);
    end else begin
      idx_a = mode_q ? (KEY_W'(NUM_KEYS - 1) - KEY_W'(round_q)) : KEY_W'(round_q);
      idx_b = '0;
    end
  end

  assign mix_in = l_q ^ key_a;

  sfc_subkey_file #(.N(NUM_KEYS), .W(WORD_W), .IW(IDX_W)) u_keys (
    .clk    (clk),
    .we     (wr_open && (tbl_sel == SEL_KEYS)),
    .widx   (tbl_idx),
    .wdata  (tbl_data),
    .ridx_a (idx_a),
    .rdata_a(key_a),
    .ridx_b (idx_b),
    .rdata_b(key_b)
  );

  for (genvar g = 0; g < N_TABLE; g++) begin : g_tbl
    sfc_sbox_ram #(.AW(BYTE_W), .W(WORD_W)) u_ram (
      .clk  (clk),
      .we   (wr_open && (tbl_sel == SEL_W'(g))),
      .waddr(tbl_idx[BYTE_W-1:0]),
      .wdata(tbl_data),
      .raddr(mix_in[WORD_W-1-BYTE_W*g -: BYTE_W]),
      .rdata(tq[g])
    );
  end

  sfc_round_fn #(.W(WORD_W)) u_fn (
    .q0(tq[0]), .q1(tq[1]), .q2(tq[2]), .q3(tq[3]), .f(f_val)
  );

  // Controller: the only reset state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      round_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOOK;
          round_q <= '0;
        end
        ST_LOOK: state_q <= ST_MIX;
        ST_MIX: begin
          if (round_q == RND_W'(NUM_ROUNDS - 1)) state_q <= ST_FINAL;
          else begin
            state_q <= ST_LOOK;
            round_q <= round_q + 1'b1;
          end
        end
        ST_FINAL: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Datapath: halves, direction and result are not reset.
  always_ff @(posedge clk) begin
    case (state_q)
      ST_IDLE: if (accept) begin
        l_q    <= in_block[2*WORD_W-1:WORD_W];
        r_q    <= in_block[WORD_W-1:0];
        mode_q <= decrypt;
      end
      ST_LOOK: l_q <= mix_in;
      ST_MIX: begin
        l_q <= r_q ^ f_val;
        r_q <= l_q;
      end
      ST_FINAL: out_block <= {r_q ^ key_a, l_q ^ key_b};
      default: ;
    endcase
  end

  // Cycle counter used only by the latency check.
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LAT_W'(LATENCY)));

  a_r7_busy_start_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));

  a_r8_out_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_FINAL) |=> $stable(out_block));

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_sfc_core.sv
module tb_sfc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic [7:0]  tbl_idx = '0;
  logic [31:0] tbl_data = '0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [63:0] in_block = '0;
  logic        busy, done;
  logic [63:0] out_block;

  int total = 0;
  int bad   = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] s_ref [4][256];
  logic [31:0] p_ref [18];

  always #2 clk = ~clk;  // 250 MHz

  sfc_core dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .start(start), .decrypt(decrypt), .in_block(in_block),
    .busy(busy), .done(done), .out_block(out_block)
  );

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  function automatic logic [31:0] rf(input logic [31:0] x);
    return ((s_ref[0][x[31:24]] + s_ref[1][x[23:16]]) ^ s_ref[2][x[15:8]]) + s_ref[3][x[7:0]];
  endfunction

  function automatic logic [63:0] ref_cipher(input logic dec, input logic [63:0] b);
    logic [31:0] l = b[63:32];
    logic [31:0] r = b[31:0];
    logic [31:0] t;
    for (int i = 0; i < 16; i++) begin
      l = l ^ p_ref[dec ? 17 - i : i];
      r = r ^ rf(l);
      t = l; l = r; r = t;
    end
    return {r ^ p_ref[dec ? 0 : 17], l ^ p_ref[dec ? 1 : 16]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] idx, input logic [31:0] d);
    tbl_we = 1'b1; tbl_sel = sel; tbl_idx = idx; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Runs one op from a negedge; optional extra start at lat==5 with another block.
  task automatic run_op(input logic m, input logic [63:0] b, input logic intf,
                        output logic [63:0] res, output int lat);
    start = 1'b1; decrypt = m; in_block = b;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (intf && lat == 5) begin
        start = 1'b1; decrypt = ~m; in_block = ~b;
      end else start = 1'b0;
    end
    start = 1'b0;
    res = out_block;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] res, res2, blk, exp;
    int lat;
    repeat (3) @(negedge clk);
    // R10/R11 reset state
    chk(busy == 1'b0, "R10 reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // Pseudo-random fill of all tables and keys (R5)
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 256; i++) begin
        seed = nxt(seed); s_ref[t][i] = seed; wr(3'(t), 8'(i), seed);
      end
    for (int i = 0; i < 18; i++) begin
      seed = nxt(seed); p_ref[i] = seed; wr(3'd4, 8'(i), seed);
    end

    // R1/R2/R3 single known pattern, with R6 latency
    blk = 64'h0123_4567_89ab_cdef;
    run_op(1'b0, blk, 1'b0, res, lat);
    exp = ref_cipher(1'b0, blk);
    chk(res == exp, "R2 round function", res, exp);
    chk(lat == 33, "R6 latency", 64'(lat), 64'd33);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", 64'(done), 64'd0);
    // R1: swapping input halves changes the result as the reference predicts
    run_op(1'b0, {blk[31:0], blk[63:32]}, 1'b0, res, lat);
    exp = ref_cipher(1'b0, {blk[31:0], blk[63:32]});
    chk(res == exp, "R1 half order", res, exp);

    // R8: held through idle cycles
    repeat (10) @(negedge clk);
    chk(out_block == exp, "R8 output held", out_block, exp);

    // R3/R4 random sweep
    for (int n = 0; n < 40; n++) begin
      seed = nxt(seed); blk[63:32] = seed;
      seed = nxt(seed); blk[31:0] = seed;
      run_op(1'b0, blk, 1'b0, res, lat);
      exp = ref_cipher(1'b0, blk);
      chk(res == exp, "R3 encrypt", res, exp);
      run_op(1'b1, res, 1'b0, res2, lat);
      chk(res2 == blk, "R4 round trip", res2, blk);
      exp = ref_cipher(1'b1, blk);
      run_op(1'b1, blk, 1'b0, res2, lat);
      chk(res2 == exp, "R4 decrypt", res2, exp);
    end

    // R7: start while busy ignored
    blk = 64'hfeed_face_cafe_beef;
    run_op(1'b0, blk, 1'b1, res, lat);
    exp = ref_cipher(1'b0, blk);
    chk(res == exp, "R7 start while busy", res, exp);
    chk(lat == 33, "R7 latency unchanged", 64'(lat), 64'd33);

    // R9: key write while busy ignored
    start = 1'b1; decrypt = 1'b0; in_block = blk;
    @(negedge clk);
    start = 1'b0;
    wr(3'd4, 8'd0, 32'hdead_0000);
    wr(3'd0, 8'd7, 32'hdead_0001);
    while (!done) @(negedge clk);
    run_op(1'b0, blk, 1'b0, res, lat);
    chk(res == exp, "R9 write while busy", res, exp);

    // R5: bad select and out-of-range key index ignored; valid write works
    wr(3'd5, 8'd0, 32'h5555_aaaa);
    wr(3'd7, 8'd1, 32'h7777_0000);
    wr(3'd4, 8'd18, 32'h1818_1818);
    wr(3'd4, 8'd200, 32'hc8c8_c8c8);
    run_op(1'b0, blk, 1'b0, res, lat);
    chk(res == exp, "R5 ignored writes", res, exp);
    p_ref[3] = 32'h0bad_f00d; wr(3'd4, 8'd3, 32'h0bad_f00d);
    s_ref[3][8'h42] = 32'h1111_2222; wr(3'd3, 8'h42, 32'h1111_2222);
    exp = ref_cipher(1'b0, blk);
    run_op(1'b0, blk, 1'b0, res, lat);
    chk(res == exp, "R5 valid writes", res, exp);

    // R10: reset mid-operation, tables kept
    start = 1'b1; decrypt = 1'b1; in_block = ~blk;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R10 mid reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R10 mid reset done", 64'(done), 64'd0);
    run_op(1'b0, blk, 1'b0, res, lat);
    chk(res == exp, "R10 tables kept", res, exp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule